// File: doc/BRIEF.md
# Programmable Test Clock Generator

This block derives a test clock for a serial scan bus from the system clock. It runs at a programmable division ratio. Alongside the clock it produces one-cycle rise and fall strobes in the system clock domain. The rest of the scan controller uses these strobes to launch its outputs on a falling edge and to capture return data on a rising edge. Every edge of the test clock is itself a registered output, so the clock and its strobes line up to the cycle.

There are three modes. In free-running mode the test clock toggles all the time. In gated mode it rests low and runs only while the sequencer raises its activity request. In step mode the host moves the clock one edge at a time through a pulse input, which suits targets that need hand-built sequences. The block has no data stream, so every pin is a plain control or status level.

Top module: `tck_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tck`, `tck_rise` and `tck_fall` are all low.
- R2: In free-running mode (`mode_sel` = 2'b00) with a ratio N, each high phase and each low phase of `tck` lasts N+1 clock cycles, giving a period of 2·(N+1) cycles.
- R3: A new value on `div_ratio` is adopted at the next rising edge of `tck`. The phases before that edge keep the old length, and the phases from that edge onward use the new one.
- R4: In gated mode (`mode_sel` = 2'b01 or 2'b11), while `run_req` is low and `tck` is low, `tck` stays low and neither strobe fires.
- R5: In gated mode, starting from rest, the first rising edge of `tck` is seen N+1 cycles after `run_req` is raised. The opening low phase is therefore always full length.
- R6: In gated mode, if `run_req` drops during a high phase, that phase completes at full length and `tck` then rests low. If it drops during a low phase, `tck` stays low, and raising `run_req` again yields a fresh full N+1 cycle low phase.
- R7: In step mode (`mode_sel` = 2'b10), each one-cycle pulse on `host_step` inverts `tck` in the next cycle. Without a pulse `tck` holds, whatever the values of `run_req` and `div_ratio`.
- R8: `tck_rise` is high for exactly the cycle in which `tck` is first high, and `tck_fall` is high for exactly the cycle in which `tck` is first low. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 00 free-running, 01/11 gated, 10 host step |
| div_ratio | input | DIV_W | Ratio N; half period is N+1 cycles |
| run_req | input | 1 | Sequencer activity request (gated mode) |
| host_step | input | 1 | One-cycle pulse that inverts tck (step mode) |
| tck | output | 1 | Test clock level |
| tck_rise | output | 1 | Strobe in the cycle tck has just risen |
| tck_fall | output | 1 | Strobe in the cycle tck has just fallen |

## Verification
The assertions assume that `mode_sel` changes only while `tck` is low and the generator is at rest. They also assume that `host_step` arrives as isolated single-cycle pulses. The stimulus respects both assumptions. It switches modes only after a falling edge has been observed or while gated mode is idle. It drives every step pulse at a negative edge for one cycle and lets it drop before the next one. Ratio changes are made right after an observed rising edge, so the expected phase lengths around the switch can be stated exactly.

// File: rtl/tck_gen_pkg.sv
package tck_gen_pkg;
  typedef enum logic [1:0] {
    MODE_FREE  = 2'b00,
    MODE_GATED = 2'b01,
    MODE_STEP  = 2'b10,
    MODE_GATE2 = 2'b11
  } tck_mode_e;
endpackage

// File: rtl/tck_run_ctl.sv
module tck_run_ctl
  import tck_gen_pkg::*;
(
  input  tck_mode_e mode,
  input  logic      run_req,
  input  logic      tck_q,
  output logic      run_en,
  output logic      step_mode
);
  always_comb begin
    run_en    = 1'b0;
    step_mode = 1'b0;
    unique case (mode)
      MODE_FREE:  run_en = 1'b1;
      MODE_STEP:  step_mode = 1'b1;
      // a high phase always finishes, so the clock rests low
      MODE_GATED, MODE_GATE2: run_en = run_req | tck_q;
      default:    run_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/tck_div_ctr.sv
module tck_div_ctr #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tck_q,
  input  logic [DIV_W-1:0] div_ratio,
  output logic             wrap
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_q;
  logic             load;

  assign wrap = run_en && (cnt == div_q);
  // ratio adopted at a rising edge, or anytime the divider rests
  assign load = !run_en || (wrap && !tck_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= '0;
    end else begin
      if (!run_en || wrap) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
      if (load) div_q <= div_ratio;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= div_q);  // R2
  AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && tck_q) |=> $stable(div_q));  // R3
endmodule

// File: rtl/tck_edge_reg.sv
module tck_edge_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  output logic tck_q,
  output logic rise_q,
  output logic fall_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tck_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      tck_q  <= tck_q ^ toggle;
      rise_q <= toggle && !tck_q;
      fall_q <= toggle && tck_q;
    end
  end

  AST_RISE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (tck_q && !$past(tck_q)));  // R8
  AST_FALL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> (!tck_q && $past(tck_q)));  // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_q && fall_q));  // R8
endmodule

// File: rtl/tck_gen.sv
module tck_gen
  import tck_gen_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             run_req,
  input  logic             host_step,
  output logic             tck,
  output logic             tck_rise,
  output logic             tck_fall
);
  tck_mode_e mode;
  logic      run_en;
  logic      step_mode;
  logic      wrap;
  logic      toggle;

  assign mode   = tck_mode_e'(mode_sel);
  assign toggle = step_mode ? host_step : wrap;

  tck_run_ctl u_ctl (
    .mode      (mode),
    .run_req   (run_req),
    .tck_q     (tck),
    .run_en    (run_en),
    .step_mode (step_mode)
  );

  tck_div_ctr #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .tck_q     (tck),
    .div_ratio (div_ratio),
    .wrap      (wrap)
  );

  tck_edge_reg u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .toggle (toggle),
    .tck_q  (tck),
    .rise_q (tck_rise),
    .fall_q (tck_fall)
  );

  AST_GATED_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[0] && !run_req && !tck) |=> (!tck && !tck_rise));  // R4
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && !host_step) |=> $stable(tck));  // R7
  AST_STEP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && host_step) |=> (tck != $past(tck)));  // R7
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> (!tck && !tck_rise && !tck_fall));  // R1
endmodule

// File: tb/tb_tck_gen.sv
module tb_tck_gen;
  localparam int DIV_W = 8;
  localparam realtime PER = 8ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode_sel = 2'b01;
  logic [DIV_W-1:0] div_ratio = 8'd2;
  logic             run_req = 1'b0;
  logic             host_step = 1'b0;
  logic             tck, tck_rise, tck_fall;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit track = 1'b0;
  bit mon_on = 1'b0;
  logic prev_tck = 1'b0;
  int held = 0;
  event rise_ev, fall_ev;

  always #(PER/2) clk = ~clk;

  tck_gen #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .div_ratio(div_ratio),
    .run_req(run_req), .host_step(host_step),
    .tck(tck), .tck_rise(tck_rise), .tck_fall(tck_fall)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: strobe agreement (R8) and scoreboard of phase lengths
  always @(negedge clk) begin
    if (mon_on) begin
      check(tck_rise == (tck && !prev_tck), "R8 rise strobe", tck_rise, tck && !prev_tck);
      check(tck_fall == (!tck && prev_tck), "R8 fall strobe", tck_fall, !tck && prev_tck);
      if (tck != prev_tck) begin
        if (track && exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          check(held == e, "R2/R3/R6 phase length", held, e);
        end
        held = 1;
        prev_tck = tck;
        if (tck) -> rise_ev; else -> fall_ev;
      end else held++;
    end
  end

  task automatic push_phases(input int len, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(len);
    track = 1'b1;
    wait (exp_q.size() == 0);
    track = 1'b0;
  endtask

  task automatic expect_rest(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(!tck && !tck_rise && !tck_fall, req, tck, 0);
    end
  endtask

  task automatic start_and_time(input int n, input string req);
    realtime t0;
    t0 = $realtime;
    run_req = 1'b1;
    @(rise_ev);
    check(int'(($realtime - t0) / PER) == n + 1, req, int'(($realtime - t0) / PER), n + 1);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", wd);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!tck && !tck_rise && !tck_fall, "R1 in reset", tck, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tck && !tck_rise && !tck_fall, "R1 after reset", tck, 0);
    mon_on = 1'b1;

    // R4: gated, no request
    div_ratio = 8'd3;
    expect_rest(20, "R4 gated idle");

    // R5: first rise after full low phase
    start_and_time(3, "R5 gated start");
    // R6: drop during high phase, high completes then rest
    run_req = 1'b0;
    push_phases(4, 1);
    expect_rest(30, "R6 rest after high");

    // R6: drop during low phase, then restart with full low
    start_and_time(3, "R5 second start");
    @(fall_ev);
    @(negedge clk);
    @(negedge clk);
    run_req = 1'b0;
    expect_rest(20, "R6 drop in low");
    start_and_time(3, "R6 restart full low");
    run_req = 1'b0;
    @(fall_ev);
    expect_rest(5, "R6 rest");

    // R7: step mode ignores request and ratio
    mode_sel = 2'b10;
    run_req = 1'b1;
    div_ratio = 8'd0;
    expect_rest(20, "R7 hold without step");
    host_step = 1'b1;
    @(negedge clk);
    host_step = 1'b0;
    check(tck && tck_rise, "R7 step to high", tck, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(tck && !tck_rise, "R7 hold high", tck, 1);
    end
    host_step = 1'b1;
    @(negedge clk);
    host_step = 1'b0;
    check(!tck && tck_fall, "R7 step to low", tck, 0);
    expect_rest(5, "R7 hold low");

    // R2: free running, ratio 2
    div_ratio = 8'd2;
    run_req = 1'b0;
    mode_sel = 2'b00;
    @(rise_ev);
    push_phases(3, 8);
    // R2: ratio 0
    @(rise_ev);
    div_ratio = 8'd0;
    push_phases(3, 2);
    push_phases(1, 6);

    // R3: ratio change right after a rise
    @(rise_ev);
    div_ratio = 8'd4;
    exp_q.push_back(1);
    exp_q.push_back(1);
    push_phases(5, 6);
    @(rise_ev);
    div_ratio = 8'd1;
    exp_q.push_back(5);
    exp_q.push_back(5);
    push_phases(2, 6);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule